// File: doc/BRIEF.md
# Dual-View Region Access Permission Unit

This block keeps access permission codes for eight memory regions. Instruction fetches and data accesses have separate sets of codes, and both sets use the same layout. A single register port reaches both sets through two views. The wide view gives each region a 4-bit code. The narrow view gives each region a 2-bit code and keeps software written for the smaller format working. Both views alias the same storage.

A combinational checker answers one access query at a time. The query gives a region number, the side (instruction or data), the privilege level and the direction (read or write), and the checker returns allow or deny. When the protection-enable input is low, every access is allowed.

Stored codes that have no defined meaning are resolved to "deny everything". This means that no code pattern can grant an access that the defined codes do not grant.

Top module: `region_perm_unit`

## Requirements
- R1: After a synchronous active-high reset, every stored code is 0000. All four views read back as zero, and with protection enabled every query is denied.
- R2: `reg_view` selects the target as follows: 0 is data narrow, 1 is instruction narrow, 2 is data wide and 3 is instruction wide. A write to one side never changes the other side's codes.
- R3: In a wide view, region n occupies bits [4n+3:4n] of the 32-bit word, for both writes and reads.
- R4: A narrow-view write takes region n's code from bits [2n+1:2n] of `reg_wdata` and stores it with its upper two bits set to 00. Bits [31:16] of the write data are ignored.
- R5: A narrow-view read returns the low two bits of region n's stored code at bits [2n+1:2n]. Bits [31:16] read as zero.
- R6: Each defined code decodes to a privileged permission and a user permission:
  - 0000 gives none for privileged and none for user.
  - 0001 gives read-write for privileged and none for user.
  - 0010 gives read-write for privileged and read-only for user.
  - 0011 gives read-write for privileged and read-write for user.
  - 0101 gives read-only for privileged and none for user.
  - 0110 gives read-only for privileged and read-only for user.
- R7: The codes 0100, 0111 and 1xxx deny every access at both privilege levels while protection is enabled.
- R8: While `prot_en` is low, `q_allow` is 1 for every query, whatever codes are stored.
- R9: A write takes effect at the next rising clock edge. The stored codes, and so `reg_rdata` for a fixed view, do not change while `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_view | input | 2 | View selector (side and width) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected view (combinational) |
| prot_en | input | 1 | Protection enable |
| q_region | input | 3 | Region number of the query |
| q_instr | input | 1 | Query side: 1 for instruction, 0 for data |
| q_priv | input | 1 | Query privilege: 1 for privileged, 0 for user |
| q_write | input | 1 | Query direction: 1 for write, 0 for read |
| q_allow | output | 1 | 1 when the queried access is permitted |

## Verification
The hardest case to reach is the aliasing between the two views. The upper code bits are cleared only when a narrow write lands on storage that already holds wide codes with those bits set, and the effect is visible only through a wide read or through a query.

The stimulus first fills the data side with all-ones through the wide view, so every region holds an undefined code. It then writes a narrow pattern with its upper half also set. Finally it reads the wide view back and queries a region whose code becomes a defined grant only once the upper bits are cleared.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

    parameter int unsigned NUM_REGIONS = 8;
    parameter int unsigned CODE_W      = 4;
    parameter int unsigned NARROW_W    = 2;
    parameter int unsigned BUS_W       = 32;

    localparam int unsigned REGION_IDX_W = $clog2(NUM_REGIONS);
    localparam int unsigned WIDE_BITS    = NUM_REGIONS * CODE_W;
    localparam int unsigned NARROW_BITS  = NUM_REGIONS * NARROW_W;

    typedef enum logic [1:0] {
        VIEW_D_NARROW = 2'd0,
        VIEW_I_NARROW = 2'd1,
        VIEW_D_WIDE   = 2'd2,
        VIEW_I_WIDE   = 2'd3
    } view_e;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic priv_rd;
        logic priv_wr;
        logic usr_rd;
        logic usr_wr;
    } perm_t;

    function automatic logic view_is_wide(view_e v);
        return v[1];
    endfunction

    function automatic logic view_is_instr(view_e v);
        return v[0];
    endfunction

    // Undefined codes fall to the default branch and grant nothing.
    function automatic perm_t decode_code(code_t c);
        perm_t p;
        p = '0;
        case (c)
            4'b0001: p = '{priv_rd: 1'b1, priv_wr: 1'b1, usr_rd: 1'b0, usr_wr: 1'b0};
            4'b0010: p = '{priv_rd: 1'b1, priv_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b0};
            4'b0011: p = '{priv_rd: 1'b1, priv_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b1};
            4'b0101: p = '{priv_rd: 1'b1, priv_wr: 1'b0, usr_rd: 1'b0, usr_wr: 1'b0};
            4'b0110: p = '{priv_rd: 1'b1, priv_wr: 1'b0, usr_rd: 1'b1, usr_wr: 1'b0};
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rpu_bank.sv
module rpu_bank
    import rpu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wide,
    input  logic [BUS_W-1:0]     wdata,
    output logic [WIDE_BITS-1:0] codes
);

    for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_region
        code_t code_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= '0;
            end else if (wr_en) begin
                if (wide) begin
                    code_q <= wdata[n*CODE_W +: CODE_W];
                end else begin
                    code_q <= code_t'(wdata[n*NARROW_W +: NARROW_W]);
                end
            end
        end

        assign codes[n*CODE_W +: CODE_W] = code_q;
    end

endmodule

// File: rtl/rpu_readmux.sv
module rpu_readmux
    import rpu_pkg::*;
(
    input  logic [WIDE_BITS-1:0] d_codes,
    input  logic [WIDE_BITS-1:0] i_codes,
    input  view_e                view,
    output logic [BUS_W-1:0]     rdata
);

    logic [WIDE_BITS-1:0]   side_codes;
    logic [NARROW_BITS-1:0] packed_low;

    assign side_codes = view_is_instr(view) ? i_codes : d_codes;

    for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_pack
        assign packed_low[n*NARROW_W +: NARROW_W] = side_codes[n*CODE_W +: NARROW_W];
    end

    always_comb begin
        if (view_is_wide(view)) begin
            rdata = BUS_W'(side_codes);
        end else begin
            rdata = BUS_W'(packed_low);
        end
    end

endmodule

// File: rtl/rpu_access_check.sv
module rpu_access_check
    import rpu_pkg::*;
(
    input  logic [WIDE_BITS-1:0]    d_codes,
    input  logic [WIDE_BITS-1:0]    i_codes,
    input  logic [REGION_IDX_W-1:0] region,
    input  logic                    instr,
    input  logic                    priv,
    input  logic                    write,
    input  logic                    prot_en,
    output logic                    allow
);

    code_t code;
    perm_t perm;
    logic  granted;

    always_comb begin
        if (instr) begin
            code = i_codes[region*CODE_W +: CODE_W];
        end else begin
            code = d_codes[region*CODE_W +: CODE_W];
        end
        perm = decode_code(code);
        case ({priv, write})
            2'b11:   granted = perm.priv_wr;
            2'b10:   granted = perm.priv_rd;
            2'b01:   granted = perm.usr_wr;
            default: granted = perm.usr_rd;
        endcase
        allow = !prot_en || granted;
    end

endmodule

// File: rtl/region_perm_unit.sv
module region_perm_unit
    import rpu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [1:0]              reg_view,
    input  logic [BUS_W-1:0]        reg_wdata,
    output logic [BUS_W-1:0]        reg_rdata,
    input  logic                    prot_en,
    input  logic [REGION_IDX_W-1:0] q_region,
    input  logic                    q_instr,
    input  logic                    q_priv,
    input  logic                    q_write,
    output logic                    q_allow
);

    view_e                view;
    logic [WIDE_BITS-1:0] d_codes;
    logic [WIDE_BITS-1:0] i_codes;
    logic                 d_we;
    logic                 i_we;

    assign view = view_e'(reg_view);
    assign d_we = reg_we && !view_is_instr(view);
    assign i_we = reg_we &&  view_is_instr(view);

    rpu_bank i_dbank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (d_we),
        .wide  (view_is_wide(view)),
        .wdata (reg_wdata),
        .codes (d_codes)
    );

    rpu_bank i_ibank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (i_we),
        .wide  (view_is_wide(view)),
        .wdata (reg_wdata),
        .codes (i_codes)
    );

    rpu_readmux i_rmux (
        .d_codes (d_codes),
        .i_codes (i_codes),
        .view    (view),
        .rdata   (reg_rdata)
    );

    rpu_access_check i_chk (
        .d_codes (d_codes),
        .i_codes (i_codes),
        .region  (q_region),
        .instr   (q_instr),
        .priv    (q_priv),
        .write   (q_write),
        .prot_en (prot_en),
        .allow   (q_allow)
    );

endmodule

// File: rtl/rpu_checker.sv
module rpu_checker
    import rpu_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_we,
    input logic [1:0]              reg_view,
    input logic [BUS_W-1:0]        reg_rdata,
    input logic                    prot_en,
    input logic                    q_allow
);

    // R8
    prot_off_allows_chk: assert property (@(posedge clk) disable iff (rst)
        !prot_en |-> q_allow);

    // R5
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_view[1] |-> (reg_rdata[BUS_W-1:NARROW_BITS] == '0));

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> ((reg_view != $past(reg_view)) || $stable(reg_rdata)));

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_rdata == '0));

endmodule

bind region_perm_unit rpu_checker i_rpu_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_view  (reg_view),
    .reg_rdata (reg_rdata),
    .prot_en   (prot_en),
    .q_allow   (q_allow)
);

// File: tb/test_region_perm_unit.sv
module test_region_perm_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_view;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        prot_en;
    logic [2:0]  q_region;
    logic        q_instr;
    logic        q_priv;
    logic        q_write;
    logic        q_allow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_perm_unit i_region_perm_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_view  (reg_view),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prot_en   (prot_en),
        .q_region  (q_region),
        .q_instr   (q_instr),
        .q_priv    (q_priv),
        .q_write   (q_write),
        .q_allow   (q_allow)
    );

    typedef struct packed {
        logic [1:0]  view;
        logic [31:0] wdata;
        logic [2:0]  region;
        logic        instr;
        logic        priv;
        logic        wr;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // R6 and R7 vectors: each codes 0..7 into regions 0..7.
    // R2 vectors: the side not written keeps its own codes.
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 32'h7654_3210, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{2'd2, 32'h7654_3210, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},
        '{2'd2, 32'h7654_3210, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
        '{2'd2, 32'h7654_3210, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
        '{2'd3, 32'h8888_3333, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},
        '{2'd3, 32'h8888_3333, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{2'd3, 32'h8888_3333, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2},
        '{2'd3, 32'hF888_3333, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 4'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] v, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_view  = v;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic read_view(input logic [1:0] v, output logic [31:0] d);
        reg_view = v;
        #1;
        d = reg_rdata;
    endtask

    task automatic query(input logic [2:0] r, input logic i, input logic p,
                         input logic w, output logic a);
        q_region = r;
        q_instr  = i;
        q_priv   = p;
        q_write  = w;
        #1;
        a = q_allow;
    endtask

    initial begin
        logic [31:0] rd;
        logic        a;
        rst = 1'b1; reg_we = 1'b0; reg_view = 2'd0; reg_wdata = '0;
        prot_en = 1'b1; q_region = '0; q_instr = 1'b0; q_priv = 1'b0; q_write = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: every view reads zero and every query is denied
        for (int v = 0; v < 4; v++) begin
            read_view(2'(v), rd);
            check("R1 reset read", rd, 32'h0);
        end
        query(3'd3, 1'b0, 1'b1, 1'b0, a);
        check("R1 reset query", {31'h0, a}, 32'h0);
        query(3'd6, 1'b1, 1'b0, 1'b1, a);
        check("R1 reset query", {31'h0, a}, 32'h0);

        // R6 R7 R2 table walk
        for (int k = 0; k < NV; k++) begin
            do_write(VECS[k].view, VECS[k].wdata);
            query(VECS[k].region, VECS[k].instr, VECS[k].priv, VECS[k].wr, a);
            n_tests++;
            if (a !== VECS[k].exp) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual %b expected %b",
                         VECS[k].req, k, a, VECS[k].exp);
            end
        end

        // R3: wide layout round trip on the instruction side
        do_write(2'd3, 32'h1234_5678);
        read_view(2'd3, rd);
        check("R3 wide readback", rd, 32'h1234_5678);
        // R5: narrow read packs the low two bits of each code
        read_view(2'd1, rd);
        check("R5 narrow readback", rd, 32'h0000_6C6C);

        // R4: narrow write over undefined codes clears the upper bits
        do_write(2'd2, 32'hFFFF_FFFF);
        query(3'd3, 1'b0, 1'b0, 1'b1, a);
        check("R7 all ones denies", {31'h0, a}, 32'h0);
        do_write(2'd0, 32'hFFFF_E4E4);
        read_view(2'd2, rd);
        check("R4 narrow write alias", rd, 32'h3210_3210);
        read_view(2'd0, rd);
        check("R5 narrow read upper zero", rd, 32'h0000_E4E4);
        query(3'd3, 1'b0, 1'b0, 1'b1, a);
        check("R4 cleared upper bits grant", {31'h0, a}, 32'h1);
        read_view(2'd3, rd);
        check("R2 instr side untouched", rd, 32'h1234_5678);

        // R9: write lands only at the next edge; no write keeps state
        @(negedge clk);
        reg_view = 2'd3; reg_wdata = 32'hAAAA_AAAA; reg_we = 1'b1;
        #1;
        check("R9 before edge", reg_rdata, 32'h1234_5678);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 32'h5555_5555;
        #1;
        check("R9 after edge", reg_rdata, 32'hAAAA_AAAA);
        repeat (2) @(negedge clk);
        #1;
        check("R9 we low holds", reg_rdata, 32'hAAAA_AAAA);

        // R8: protection off allows a region coded 0000
        query(3'd4, 1'b0, 1'b0, 1'b1, a);
        check("R8 prot on denies", {31'h0, a}, 32'h0);
        prot_en = 1'b0;
        query(3'd4, 1'b0, 1'b0, 1'b1, a);
        check("R8 prot off allows", {31'h0, a}, 32'h1);
        query(3'd0, 1'b1, 1'b1, 1'b0, a);
        check("R8 prot off allows undefined", {31'h0, a}, 32'h1);
        prot_en = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule